// File: doc/BRIEF.md
# Protected Top-of-Memory Window Guard

This block sits beside a memory controller and guards a window of system-management memory placed at the top of installed RAM. Software reaches two byte-wide registers through a plain register port: a control register, which holds the open, closed, global-enable and lock bits, and a window register, which holds a size code and a window-enable bit. Setting the lock bit is sticky. It forces the open bit low and freezes the settings that guard the window. Only a synchronous system reset releases the lock.

Every memory access from the controller also passes through a combinational decode. The decode compares the address with the window. The window ends at the top of installed RAM, and its size comes from the size code. An access that hits a guarded window and is not made in management mode is blocked. A blocked read returns 0xFF in place of memory data, and a blocked write never reaches memory. Any other access passes through unchanged.

Top module: `smram_guard`

## Requirements
- R1: After a synchronous reset both registers read 0x00, the lock is clear and no memory access is blocked.
- R2: Control register (select 0) layout: bit0 open, bit1 closed, bit2 global enable, bit3 lock, and bits 7:4 read 0. Window register (select 1) layout: bit0 window enable, bits 2:1 size code, and bits 7:3 read 0. While unlocked, every field reads back what was last written.
- R3: A control write with bit3 set sets the lock and clears the open bit in that same write, whatever value bit0 carries.
- R4: While locked, control writes change only the closed bit. The open bit stays 0, and the global-enable and lock bits keep their values.
- R5: The lock stays set through any register write and clears only on reset. After reset the open bit can be written again.
- R6: While locked, writes to the window register are ignored.
- R7: Size codes: 0 gives 1 MB, 1 gives 2 MB, 2 gives 8 MB, and 3 gives EXT_MB megabytes.
- R8: The window spans from RAM_MB·2^20 − size·2^20 up to, but not including, RAM_MB·2^20. The byte just below the base and any address at or above the RAM top are never blocked.
- R9: An access is blocked when it is valid, lies inside the window, the window is enabled, global enable is set, the open bit is 0 and the management flag is low. A blocked read returns 0xFF, and a blocked write does not raise dram_we.
- R10: An access that is not blocked returns dram_rdata unchanged, and a write of this kind raises dram_we.
- R11: An access with mem_smm high is never blocked.
- R12: While the open bit is 1, non-management accesses to the window pass through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous system reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 window |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| mem_valid | input | 1 | Memory access present |
| mem_write | input | 1 | Access is a write |
| mem_smm | input | 1 | Access made in management mode |
| mem_addr | input | ADDR_W | Byte address of the access |
| dram_rdata | input | 8 | Data read from memory |
| mem_rdata | output | 8 | Read data returned to the requester |
| dram_we | output | 1 | Write enable forwarded to memory |
| mem_blocked | output | 1 | Access hit the guarded window and was blocked |

## Verification
The hardest state to reach is a locked register set with every window size in turn. The lock can be left only through reset, so each size needs its own reset, configure and lock sequence. Directed passes do this for all four codes. They probe the addresses base−1, base, top−1 and top, both in and out of management mode. A seeded random phase then mixes register writes, occasional lock writes, rare resets and accesses biased toward the window edges, so that unlocked and locked behaviour interleave.

// File: rtl/smram_pkg.sv
package smram_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned MB_W   = 16;
    localparam int unsigned MB_SHIFT = 20;

    typedef enum logic [1:0] {
        SZ_1M  = 2'd0,
        SZ_2M  = 2'd1,
        SZ_8M  = 2'd2,
        SZ_EXT = 2'd3
    } size_code_e;

    typedef enum logic {
        SEL_CTL = 1'b0,
        SEL_WIN = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic       open;
        logic       closed;
        logic       gen;
        logic       lock;
        logic       win_en;
        size_code_e size;
    } guard_state_t;

    function automatic logic [MB_W-1:0] window_mb(input size_code_e code,
                                                  input logic [MB_W-1:0] ext_mb);
        logic [MB_W-1:0] mb;
        case (code)
            SZ_1M:   mb = MB_W'(1);
            SZ_2M:   mb = MB_W'(2);
            SZ_8M:   mb = MB_W'(8);
            default: mb = ext_mb;
        endcase
        return mb;
    endfunction

endpackage

// File: rtl/smram_guard_regs.sv
module smram_guard_regs
    import smram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              open_o,
    output logic              lock_o,
    output logic              gen_o,
    output logic              win_en_o,
    output size_code_e        size_o
);

    localparam int unsigned B_OPEN   = 0;
    localparam int unsigned B_CLOSED = 1;
    localparam int unsigned B_GEN    = 2;
    localparam int unsigned B_LOCK   = 3;
    localparam int unsigned B_WEN    = 0;
    localparam int unsigned B_SZ_LO  = 1;

    guard_state_t state_d, state_q;
    logic         wdata_unused;

    assign wdata_unused = ^reg_wdata[DATA_W-1:4];

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d = '0;
        end else if (reg_we) begin
            if (reg_sel == SEL_CTL) begin
                state_d.closed = reg_wdata[B_CLOSED];
                if (!state_q.lock) begin
                    state_d.lock = reg_wdata[B_LOCK];
                    state_d.gen  = reg_wdata[B_GEN];
                    state_d.open = reg_wdata[B_OPEN] & ~reg_wdata[B_LOCK];
                end
            end else if (!state_q.lock) begin
                state_d.win_en = reg_wdata[B_WEN];
                state_d.size   = size_code_e'(reg_wdata[B_SZ_LO +: 2]);
            end
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_sel == SEL_CTL) begin
            reg_rdata[B_OPEN]   = state_q.open;
            reg_rdata[B_CLOSED] = state_q.closed;
            reg_rdata[B_GEN]    = state_q.gen;
            reg_rdata[B_LOCK]   = state_q.lock;
        end else begin
            reg_rdata[B_WEN]          = state_q.win_en;
            reg_rdata[B_SZ_LO +: 2]   = state_q.size;
        end
    end

    assign open_o   = state_q.open;
    assign lock_o   = state_q.lock;
    assign gen_o    = state_q.gen;
    assign win_en_o = state_q.win_en;
    assign size_o   = state_q.size;

endmodule

// File: rtl/smram_guard_window.sv
module smram_guard_window
    import smram_pkg::*;
#(
    parameter int unsigned RAM_MB = 128,
    parameter int unsigned EXT_MB = 16,
    parameter int unsigned ADDR_W = 28
) (
    input  size_code_e        size,
    input  logic [ADDR_W-1:0] addr,
    output logic              in_window
);

    localparam logic [ADDR_W-1:0] RAM_TOP = ADDR_W'(RAM_MB) << MB_SHIFT;
    localparam logic [MB_W-1:0]   EXT_SZ  = MB_W'(EXT_MB);

    logic [MB_W-1:0]   span_mb;
    logic [ADDR_W-1:0] span_bytes;
    logic [ADDR_W-1:0] base;

    always_comb begin
        span_mb    = window_mb(size, EXT_SZ);
        span_bytes = ADDR_W'(span_mb) << MB_SHIFT;
        base       = RAM_TOP - span_bytes;
        in_window  = (addr >= base) && (addr < RAM_TOP);
    end

endmodule

// File: rtl/smram_guard_gate.sv
module smram_guard_gate
    import smram_pkg::*;
(
    input  logic              mem_valid,
    input  logic              mem_write,
    input  logic              mem_smm,
    input  logic              in_window,
    input  logic              win_en,
    input  logic              gen,
    input  logic              open,
    input  logic              lock,
    input  logic [DATA_W-1:0] dram_rdata,
    output logic [DATA_W-1:0] mem_rdata,
    output logic              dram_we,
    output logic              mem_blocked
);

    logic guarded;
    logic visible;

    always_comb begin
        guarded     = win_en & gen;
        visible     = mem_smm | (open & ~lock);
        mem_blocked = mem_valid & in_window & guarded & ~visible;
        mem_rdata   = mem_blocked ? {DATA_W{1'b1}} : dram_rdata;
        dram_we     = mem_valid & mem_write & ~mem_blocked;
    end

endmodule

// File: rtl/smram_guard.sv
module smram_guard
    import smram_pkg::*;
#(
    parameter int unsigned RAM_MB = 128,
    parameter int unsigned EXT_MB = 16,
    parameter int unsigned ADDR_W = 28
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic              reg_sel,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              mem_valid,
    input  logic              mem_write,
    input  logic              mem_smm,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        dram_rdata,
    output logic [7:0]        mem_rdata,
    output logic              dram_we,
    output logic              mem_blocked
);

    logic       st_open;
    logic       st_lock;
    logic       st_gen;
    logic       st_win_en;
    size_code_e st_size;
    logic       hit;

    smram_guard_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .open_o    (st_open),
        .lock_o    (st_lock),
        .gen_o     (st_gen),
        .win_en_o  (st_win_en),
        .size_o    (st_size)
    );

    smram_guard_window #(
        .RAM_MB (RAM_MB),
        .EXT_MB (EXT_MB),
        .ADDR_W (ADDR_W)
    ) u_window (
        .size      (st_size),
        .addr      (mem_addr),
        .in_window (hit)
    );

    smram_guard_gate u_gate (
        .mem_valid   (mem_valid),
        .mem_write   (mem_write),
        .mem_smm     (mem_smm),
        .in_window   (hit),
        .win_en      (st_win_en),
        .gen         (st_gen),
        .open        (st_open),
        .lock        (st_lock),
        .dram_rdata  (dram_rdata),
        .mem_rdata   (mem_rdata),
        .dram_we     (dram_we),
        .mem_blocked (mem_blocked)
    );

endmodule

// File: rtl/smram_guard_chk.sv
module smram_guard_chk (
    input logic       clk,
    input logic       rst,
    input logic       reg_we,
    input logic       reg_sel,
    input logic [7:0] reg_wdata,
    input logic       mem_valid,
    input logic       mem_smm,
    input logic [7:0] mem_rdata,
    input logic       dram_we,
    input logic       mem_blocked,
    input logic       st_open,
    input logic       st_lock,
    input logic       st_win_en,
    input logic [1:0] st_size
);

    assert_lock_clears_open_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_we && !reg_sel && reg_wdata[3]) |=> (st_lock && !st_open));

    assert_locked_open_low_R4: assert property (@(posedge clk) disable iff (rst)
        st_lock |-> !st_open);

    assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        st_lock |=> st_lock);

    assert_window_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        st_lock |=> ($stable(st_win_en) && $stable(st_size)));

    assert_blocked_data_R9: assert property (@(posedge clk) disable iff (rst)
        mem_blocked |-> (mem_rdata == 8'hFF && !dram_we));

    assert_smm_passes_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_smm) |-> !mem_blocked);

    assert_open_passes_R12: assert property (@(posedge clk) disable iff (rst)
        st_open |-> !mem_blocked);

endmodule

bind smram_guard smram_guard_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_we      (reg_we),
    .reg_sel     (reg_sel),
    .reg_wdata   (reg_wdata),
    .mem_valid   (mem_valid),
    .mem_smm     (mem_smm),
    .mem_rdata   (mem_rdata),
    .dram_we     (dram_we),
    .mem_blocked (mem_blocked),
    .st_open     (st_open),
    .st_lock     (st_lock),
    .st_win_en   (st_win_en),
    .st_size     (st_size)
);

// File: tb/smram_guard_bench.sv
module smram_guard_bench;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned RAM_MB = 128;
    localparam int unsigned EXT_MB = 16;
    localparam int unsigned ADDR_W = 28;
    localparam longint TOP = longint'(RAM_MB) << 20;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_we = 1'b0;
    logic              reg_sel = 1'b0;
    logic [7:0]        reg_wdata = '0;
    logic [7:0]        reg_rdata;
    logic              mem_valid = 1'b0;
    logic              mem_write = 1'b0;
    logic              mem_smm = 1'b0;
    logic [ADDR_W-1:0] mem_addr = '0;
    logic [7:0]        dram_rdata = '0;
    logic [7:0]        mem_rdata;
    logic              dram_we;
    logic              mem_blocked;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model state
    bit m_open, m_closed, m_gen, m_lock, m_wen;
    bit [1:0] m_size;

    always #(CLK_PERIOD/2) clk = ~clk;

    smram_guard #(.RAM_MB(RAM_MB), .EXT_MB(EXT_MB), .ADDR_W(ADDR_W)) u_smram_guard (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_valid(mem_valid),
        .mem_write(mem_write), .mem_smm(mem_smm), .mem_addr(mem_addr),
        .dram_rdata(dram_rdata), .mem_rdata(mem_rdata), .dram_we(dram_we),
        .mem_blocked(mem_blocked)
    );

    function automatic longint size_mb(bit [1:0] c);
        case (c)
            2'd0: return 1;
            2'd1: return 2;
            2'd2: return 8;
            default: return EXT_MB;
        endcase
    endfunction

    function automatic longint base_addr();
        return TOP - (size_mb(m_size) << 20);
    endfunction

    function automatic bit exp_block(longint a, bit smm);
        return m_wen && m_gen && !m_open && !smm && a >= base_addr() && a < TOP;
    endfunction

    function automatic logic [7:0] exp_reg(bit sel);
        if (!sel) return {4'b0, m_lock, m_gen, m_closed, m_open};
        return {5'b0, m_size, m_wen};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        {m_open, m_closed, m_gen, m_lock, m_wen, m_size} = '0;
    endtask

    task automatic wr(bit sel, logic [7:0] d);
        @(negedge clk);
        reg_sel = sel;
        reg_wdata = d;
        reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        if (!sel) begin
            m_closed = d[1];
            if (!m_lock) begin
                m_open = d[0] & ~d[3];
                m_gen  = d[2];
                m_lock = d[3];
            end
        end else if (!m_lock) begin
            m_wen  = d[0];
            m_size = d[2:1];
        end
    endtask

    task automatic rd(bit sel, string req);
        reg_sel = sel;
        #1;
        chk(req, reg_rdata, exp_reg(sel));
    endtask

    task automatic acc(longint a, bit smm, bit w, string req);
        logic [7:0] din;
        bit b;
        din = 8'($urandom);
        mem_addr = ADDR_W'(a);
        mem_smm = smm;
        mem_write = w;
        mem_valid = 1'b1;
        dram_rdata = din;
        #1;
        b = exp_block(a, smm);
        chk(req, mem_blocked, b);
        chk(req, mem_rdata, b ? 8'hFF : din);
        chk(req, dram_we, w && !b);
        mem_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        do_reset();
        // R1: reset state
        rd(0, "R1 ctl reset");
        rd(1, "R1 win reset");
        acc(TOP - 1, 0, 0, "R1 no block after reset");

        // R2: open bit free while unlocked
        wr(0, 8'h01); rd(0, "R2 open set");
        wr(0, 8'h00); rd(0, "R2 open clear");
        wr(1, 8'h05); rd(1, "R2 window fields");

        // R7/R8/R9/R11 for each size code, locked and closed
        for (int c = 0; c < 4; c++) begin
            do_reset();
            wr(1, 8'((c << 1) | 1));
            wr(0, 8'h06);
            wr(0, 8'h0F);
            rd(0, "R3 lock clears open");
            acc(base_addr() - 1, 0, 1, "R8 below base write");
            acc(base_addr() - 1, 0, 0, "R8 below base read");
            acc(base_addr(), 0, 0, "R7 R9 base read blocked");
            acc(base_addr(), 0, 1, "R9 base write suppressed");
            acc(TOP - 1, 0, 0, "R9 top-1 blocked");
            acc(TOP, 0, 0, "R8 at top passes");
            acc(base_addr(), 1, 1, "R11 smm write passes");
            acc(base_addr(), 1, 0, "R11 smm read passes");
        end

        // R4/R5/R6 while locked (state from last loop pass)
        wr(0, 8'h01); rd(0, "R4 open stays 0");
        wr(0, 8'h00); rd(0, "R5 lock sticky, closed writable R4");
        wr(1, 8'h02); rd(1, "R6 window frozen");
        do_reset();
        rd(0, "R5 lock released");
        wr(0, 8'h01); rd(0, "R5 open writable after reset");

        // R12 and R10: open lets non-smm through
        wr(1, 8'h03);
        wr(0, 8'h05);
        acc(base_addr(), 0, 1, "R12 open write passes");
        acc(TOP - 1, 0, 0, "R12 R10 open read passes");
        wr(0, 8'h04);
        acc(base_addr(), 0, 0, "R9 closed again blocks");
        acc(16, 0, 1, "R10 low address passes");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            int unsigned k;
            longint a;
            k = $urandom % 100;
            if (k < 1) begin
                do_reset();
                rd(0, "R1 random reset");
            end else if (k < 30) begin
                logic [7:0] d;
                bit s;
                d = 8'($urandom);
                s = 1'($urandom);
                if (!s && ($urandom % 15 != 0)) d[3] = 1'b0;
                wr(s, d);
                rd(s, "R2 R4 R6 random readback");
            end else begin
                case ($urandom % 6)
                    0: a = base_addr() - 1;
                    1: a = base_addr();
                    2: a = TOP - 1;
                    3: a = TOP;
                    4: a = base_addr() + longint'($urandom % 4096);
                    default: a = longint'($urandom % (1 << ADDR_W));
                endcase
                acc(a, 1'($urandom % 4 == 0), 1'($urandom), "R9 R10 R11 random access");
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule